// File: doc/BRIEF.md
# Three-Channel LED Brightness Modulator

This block turns three 8-bit loudness values, one per audio frequency band, into three pulse-width-modulated LED enables. Each output is high for a share of a fixed 256-tick frame equal to the amplitude chosen for that channel. A second mode ignores the amplitudes and holds each output fully on or fully off from a static bit per channel, which gives black plus seven colours on an RGB module. A 2-bit rate code picks one of four tick prescalers. With the default divisors the rates are 1, 2, 4 and 8 clocks per tick. An integrator sets the divisors so that, at the real system clock, the four codes give frame rates of about 15 kHz, 60 Hz, 7 Hz and 4 Hz.

A separate router supplies the mapping from bands to channels. The block also passes a 2-bit current-drive code per channel straight through to the current sinks. Every setting that shapes a frame is captured only at a frame boundary: rate, mode, static bits, mapping and amplitudes. A frame therefore never contains a partial or glitched pulse.

A small frame state machine sequences the block. ST_SHUT is the idle and dark state. It moves to ST_ARM once both shutdown and soft reset are low. ST_ARM lasts one cycle: it captures the settings, clears the counters and moves to ST_RUN. If a halt is seen in ST_ARM, the machine returns to ST_SHUT instead. ST_RUN counts ticks and recaptures the settings each time the tick position wraps from 255 to 0. It falls back to ST_SHUT as soon as shutdown or soft reset is raised.

Top module: `led_pwm_ctrl`

## Requirements
- R1: While reset is low, and afterwards for as long as `shutdown` stays 1, all three `led_on` bits are 0 and the machine stays in ST_SHUT.
- R2: `shutdown` = 1 drives all `led_on` bits to 0 from the next clock. After it is cleared, a fresh frame starts: ST_ARM is entered on the first clock and ST_RUN on the second. A static-on output is high after the third clock.
- R3: The code on `rate_sel` picks the clocks per tick: 00 = DIV0, 01 = DIV1, 10 = DIV2, 11 = DIV3 (defaults 1, 2, 4, 8). A frame is 256 ticks, and the tick position advances only on a tick.
- R4: With `pattern_sel` = 0, a channel whose captured amplitude is A is high for exactly A ticks of every 256. An amplitude of 0 never lights the channel, and 255 lights it for all ticks but one.
- R5: `band_map` bits [2c+1:2c] choose the source for channel c: 00 = `band_low`, 01 = `band_mid`, 10 = `band_high`, 11 = a constant 0. The straight mapping 6'b10_01_00 sends the low band to channel 0, the mid band to channel 1 and the high band to channel 2.
- R6: With `pattern_sel` = 1, each channel is high continuously when its `pattern_en` bit is 1 and low continuously when the bit is 0.
- R7: `rate_sel`, `pattern_sel`, `pattern_en`, `band_map` and the amplitudes take effect only at a frame boundary. A change made mid-frame leaves the outputs unchanged until that frame ends.
- R8: `soft_rst` = 1 turns all outputs off from the next clock and restarts the frame logic. Once it is released, with the control inputs unchanged, the outputs return as in R2.
- R9: `led_drive` always equals `drive_sel`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shutdown | input | 1 | 1 = all outputs dark, frame logic idle |
| soft_rst | input | 1 | 1 = restart frame logic, settings kept outside |
| pattern_sel | input | 1 | 0 = amplitude-driven duty, 1 = static pattern |
| pattern_en | input | 3 | Static on/off bit per channel |
| rate_sel | input | 2 | Tick prescaler code |
| band_low | input | 8 | Low-band amplitude |
| band_mid | input | 8 | Mid-band amplitude |
| band_high | input | 8 | High-band amplitude |
| band_map | input | 6 | Band source code per channel, 2 bits each |
| drive_sel | input | 6 | Current-drive code, 2 bits per channel |
| led_on | output | 3 | PWM enable per channel |
| led_drive | output | 6 | Current-drive code passed to the sinks |

## Verification
The hardest case to reach from the ports is a settings change that arrives in the middle of a frame, because the frame phase cannot be seen from outside. The stimulus pins the phase down: it pulses `shutdown`, which restarts the frame at a known clock. It then switches from dark amplitude mode to all-on static mode partway through a long frame at the slowest rate. The outputs must stay dark until the frame ends and then light. Duty is measured by counting high cycles over a window exactly one frame long, so the count does not depend on where the window starts.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    localparam int AMP_W  = 8;
    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        ST_SHUT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } frame_state_t;

    typedef struct packed {
        logic       pat_sel;
        logic [2:0] pat_en;
        logic [1:0] rate;
    } frame_cfg_t;

    // Pick one band amplitude by a 2-bit source code; code 3 yields zero.
    function automatic logic [AMP_W-1:0] pick_band(
        input logic [1:0]       code,
        input logic [AMP_W-1:0] lo,
        input logic [AMP_W-1:0] mid,
        input logic [AMP_W-1:0] hi
    );
        case (code)
            2'b00:   return lo;
            2'b01:   return mid;
            2'b10:   return hi;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV0 = 1,
    parameter int DIV1 = 2,
    parameter int DIV2 = 4,
    parameter int DIV3 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int M01  = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int M23  = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int MAXD = (M01 > M23) ? M01 : M23;
    localparam int PW   = (MAXD < 2) ? 1 : $clog2(MAXD + 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        case (rate)
            2'b00:   limit = PW'(DIV0 - 1);
            2'b01:   limit = PW'(DIV1 - 1);
            2'b10:   limit = PW'(DIV2 - 1);
            default: limit = PW'(DIV3 - 1);
        endcase
    end

    assign tick = enable && (pre_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clear || !enable || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/pwm_frame_fsm.sv
module pwm_frame_fsm
    import led_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             tick,
    output frame_state_t     state,
    output logic             load,
    output logic             run,
    output logic             clear_pre,
    output logic [AMP_W-1:0] pos
);
    frame_state_t next_state;
    logic         wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_SHUT;
        else
            state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_SHUT: if (!halt) next_state = ST_ARM;
            ST_ARM:  next_state = halt ? ST_SHUT : ST_RUN;
            ST_RUN:  if (halt) next_state = ST_SHUT;
            default: next_state = ST_SHUT;
        endcase
    end

    // outputs
    always_comb begin
        run       = (state == ST_RUN);
        clear_pre = (state != ST_RUN);
        wrap      = run && tick && (pos == {AMP_W{1'b1}});
        load      = (state == ST_ARM) || wrap;
    end

    // tick position inside the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos <= '0;
        else if (state != ST_RUN)
            pos <= '0;
        else if (tick)
            pos <= pos + 1'b1;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         halt,
    input  logic         pat_sel,
    input  logic         pat_bit,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] pos,
    output logic         led
);
    logic lit_next;

    always_comb begin
        lit_next = run && !halt && (pat_sel ? pat_bit : (pos < duty));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            led <= 1'b0;
        else
            led <= lit_next;
    end
endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
    import led_pwm_pkg::*;
#(
    parameter int DIV0 = 1,
    parameter int DIV1 = 2,
    parameter int DIV2 = 4,
    parameter int DIV3 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shutdown,
    input  logic       soft_rst,
    input  logic       pattern_sel,
    input  logic [2:0] pattern_en,
    input  logic [1:0] rate_sel,
    input  logic [7:0] band_low,
    input  logic [7:0] band_mid,
    input  logic [7:0] band_high,
    input  logic [5:0] band_map,
    input  logic [5:0] drive_sel,
    output logic [2:0] led_on,
    output logic [5:0] led_drive
);
    logic                              halt;
    logic                              tick;
    logic                              frame_load;
    logic                              run;
    logic                              clear_pre;
    logic [AMP_W-1:0]                  frame_pos;
    frame_state_t                      fsm_state;
    frame_cfg_t                        cfg_q;
    logic [NUM_CH-1:0][AMP_W-1:0]      duty_q;

    assign halt      = shutdown | soft_rst;
    assign led_drive = drive_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (soft_rst)
            cfg_q <= '0;
        else if (frame_load)
            cfg_q <= '{pat_sel: pattern_sel, pat_en: pattern_en, rate: rate_sel};
    end

    pwm_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .tick      (tick),
        .state     (fsm_state),
        .load      (frame_load),
        .run       (run),
        .clear_pre (clear_pre),
        .pos       (frame_pos)
    );

    pwm_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_pre),
        .enable (run),
        .rate   (cfg_q.rate),
        .tick   (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                duty_q[c] <= '0;
            else if (soft_rst)
                duty_q[c] <= '0;
            else if (frame_load)
                duty_q[c] <= pick_band(band_map[2*c+1 -: 2], band_low, band_mid, band_high);
        end

        pwm_channel #(.W(AMP_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .halt    (halt),
            .pat_sel (cfg_q.pat_sel),
            .pat_bit (cfg_q.pat_en[c]),
            .duty    (duty_q[c]),
            .pos     (frame_pos),
            .led     (led_on[c])
        );
    end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk
    import led_pwm_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         shutdown,
    input logic                         soft_rst,
    input logic [2:0]                   led_on,
    input frame_state_t                 state,
    input logic                         tick,
    input logic [AMP_W-1:0]             pos,
    input logic                         run,
    input frame_cfg_t                   cfg,
    input logic [NUM_CH-1:0][AMP_W-1:0] duty
);
    // R1
    dark_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUT) |=> (led_on == 3'b000));

    // R2
    shutdown_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (led_on == 3'b000));

    // R2
    arm_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> (state != ST_ARM));

    // R8
    soft_reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (led_on == 3'b000));

    // R3
    pos_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !shutdown && !soft_rst) |=> $stable(pos));

    // R6
    pattern_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !shutdown && !soft_rst && cfg.pat_sel) |=> (led_on == $past(cfg.pat_en)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_zero
        // R4
        zero_duty_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !cfg.pat_sel && (duty[c] == '0)) |=> !led_on[c]);
    end
endmodule

bind led_pwm_ctrl pwm_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shutdown (shutdown),
    .soft_rst (soft_rst),
    .led_on   (led_on),
    .state    (fsm_state),
    .tick     (tick),
    .pos      (frame_pos),
    .run      (run),
    .cfg      (cfg_q),
    .duty     (duty_q)
);

// File: tb/test_led_pwm_ctrl.sv
module test_led_pwm_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shutdown = 1'b1;
    logic       soft_rst = 1'b0;
    logic       pattern_sel = 1'b0;
    logic [2:0] pattern_en = 3'b000;
    logic [1:0] rate_sel = 2'b00;
    logic [7:0] band_low = 8'd0;
    logic [7:0] band_mid = 8'd0;
    logic [7:0] band_high = 8'd0;
    logic [5:0] band_map = 6'b10_01_00;
    logic [5:0] drive_sel = 6'b00_00_00;
    logic [2:0] led_on;
    logic [5:0] led_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    led_pwm_ctrl i_led_pwm_ctrl (
        .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .soft_rst(soft_rst),
        .pattern_sel(pattern_sel), .pattern_en(pattern_en), .rate_sel(rate_sel),
        .band_low(band_low), .band_mid(band_mid), .band_high(band_high),
        .band_map(band_map), .drive_sel(drive_sel),
        .led_on(led_on), .led_drive(led_drive)
    );

    // {pat_sel, pat_en, rate, map, low, mid, high, exp0, exp1, exp2}
    localparam logic [71:0] VEC [6] = '{
        // R4 R5: straight mapping at the fastest rate
        {1'b0, 3'b000, 2'b00, 6'b100100, 8'd64, 8'd128, 8'd200, 12'd64, 12'd128, 12'd200},
        // R3 R4: zero and full-scale amplitudes, two clocks per tick
        {1'b0, 3'b000, 2'b01, 6'b100100, 8'd0, 8'd255, 8'd1, 12'd0, 12'd510, 12'd2},
        // R3 R5: rotated mapping, eight clocks per tick
        {1'b0, 3'b000, 2'b11, 6'b001001, 8'd10, 8'd20, 8'd30, 12'd160, 12'd240, 12'd80},
        // R5: code 11 gives zero amplitude
        {1'b0, 3'b000, 2'b10, 6'b111100, 8'd50, 8'd90, 8'd90, 12'd200, 12'd0, 12'd0},
        // R6: static pattern 101
        {1'b1, 3'b101, 2'b00, 6'b100100, 8'd9, 8'd9, 8'd9, 12'd256, 12'd0, 12'd256},
        // R6: static pattern 010 at slowest rate
        {1'b1, 3'b010, 2'b11, 6'b100100, 8'd200, 8'd0, 8'd200, 12'd0, 12'd2048, 12'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(5);
        chk("R1 dark in reset", led_on, 0);
        rst_n = 1'b1;
        cycles(50);
        chk("R1 dark while shutdown held", led_on, 0);

        drive_sel = 6'h2D;
        #1 chk("R9 drive pass-through a", led_drive, 6'h2D);
        drive_sel = 6'h12;
        #1 chk("R9 drive pass-through b", led_drive, 6'h12);

        @(negedge clk);
        shutdown = 1'b0;
        for (int v = 0; v < 6; v++) begin
            logic [71:0] e;
            int win;
            int cnt [3];
            e = VEC[v];
            @(negedge clk);
            pattern_sel = e[71];
            pattern_en  = e[70:68];
            rate_sel    = e[67:66];
            band_map    = e[65:60];
            band_low    = e[59:52];
            band_mid    = e[51:44];
            band_high   = e[43:36];
            win = 256 << e[67:66];
            cycles(4200);
            cnt = '{0, 0, 0};
            for (int k = 0; k < win; k++) begin
                @(negedge clk);
                for (int c = 0; c < 3; c++) cnt[c] += int'(led_on[c]);
            end
            chk($sformatf("R3 R4 R5 R6 vec %0d ch0", v), cnt[0], int'(e[35:24]));
            chk($sformatf("R3 R4 R5 R6 vec %0d ch1", v), cnt[1], int'(e[23:12]));
            chk($sformatf("R3 R4 R5 R6 vec %0d ch2", v), cnt[2], int'(e[11:0]));
        end

        // R2: shutdown and restart
        pattern_sel = 1'b1; pattern_en = 3'b111; rate_sel = 2'b00;
        cycles(600);
        chk("R6 all on", led_on, 7);
        shutdown = 1'b1;
        cycles(1);
        chk("R2 off next clock", led_on, 0);
        cycles(5);
        shutdown = 1'b0;
        cycles(2);
        chk("R2 still dark during arm", led_on, 0);
        cycles(1);
        chk("R2 lit after restart", led_on, 7);

        // R8: soft reset and restart with unchanged inputs
        cycles(20);
        soft_rst = 1'b1;
        cycles(1);
        chk("R8 off next clock", led_on, 0);
        cycles(5);
        soft_rst = 1'b0;
        cycles(3);
        chk("R8 resumes after release", led_on, 7);

        // R7: mid-frame mode change waits for the boundary
        pattern_sel = 1'b0; rate_sel = 2'b11; band_map = 6'b100100;
        band_low = 8'd0; band_mid = 8'd0; band_high = 8'd0;
        shutdown = 1'b1;
        cycles(1);
        shutdown = 1'b0;
        cycles(20);
        pattern_sel = 1'b1; pattern_en = 3'b111;
        cycles(100);
        chk("R7 held until frame end", led_on, 0);
        cycles(2100);
        chk("R7 applied after frame end", led_on, 7);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule